// File: doc/BRIEF.md
# System Control Register Bank

This block is the register file behind a CPU's system-control coprocessor port. Each cycle the CPU may present one register-transfer request. The request carries a read/write flag, a primary register number, a secondary field, two opcode fields and a flag saying whether the CPU is in an unprivileged mode. In the same cycle the block answers with either a completion or a refusal. The CPU turns a refusal into an undefined-instruction trap.

Storage is two parallel banks of sixteen 32-bit words. The secondary opcode chooses the bank: a zero value selects the primary bank and any nonzero value selects the alternate bank. Before a bank is read or written, each request is screened for privilege and against a per-register table of legal secondary-field/opcode combinations. Writes to cache, TLB or translation registers are only stored; they have no side effects here.

Top module: `sysctl_regbank`

## Requirements
- R1: A request with `req_user` high is refused (`rsp_cant`=1), whatever its other fields.
- R2: A request with a nonzero `req_op1` is refused.
- R3: Registers 0 and 1 accept `req_crm`=0 with any `req_op2`. Registers 2, 3, 5, 6 and 13 accept only `req_crm`=0 together with `req_op2`=0.
- R4: Registers 4, 11 and 12 refuse every request.
- R5: Register 7 accepts exactly these (`req_op2`,`req_crm`) pairs: (0,5) (0,6) (0,7) (1,5) (1,6) (1,10) (4,10) (5,2) (6,5).
- R6: Register 8 accepts `req_op2`=0 with `req_crm` 5, 6 or 7, and `req_op2`=1 with `req_crm` 5 or 6. Nothing else is accepted.
- R7: Register 9 accepts `req_crm` 0 or 1 with `req_op2` 1 or 2. Register 10 accepts `req_crm` 0 or 1 with `req_op2`=4.
- R8: Register 14 accepts `req_op2`=0 with `req_crm` in {0,3,4,8,9}. Register 15 accepts only `req_op2`=0 with `req_crm`=1.
- R9: `req_op2`=0 addresses the primary bank and any nonzero `req_op2` addresses the alternate bank. All nonzero values reach the same alternate word for a given register number.
- R10: After reset every word is zero, except primary word 0 (0x69050000), primary word 1 (0x00000078) and alternate word 0 (0x0B1AA1AA).
- R11: In the cycle of a valid request exactly one of `rsp_done`/`rsp_cant` is high. Both are low when no request is present.
- R12: `rsp_rdata` is zero for refused requests, for writes and for idle cycles. A refused write changes no word.
- R13: An accepted write updates the addressed word at the next clock edge. An accepted read in the following cycle returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register field |
| req_op1 | input | 3 | First opcode field (must be zero) |
| req_op2 | input | 3 | Second opcode field, also bank select |
| req_user | input | 1 | CPU is in an unprivileged mode |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Request completed |
| rsp_cant | output | 1 | Request refused |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions check the response protocol on every cycle: one-hot status, zero data on refusal or write, refusal for user mode, nonzero opcode_1 and the three dead registers, and write-then-read coherence for back-to-back accesses to one word. Only the bench scenarios can show that the full legality table matches the lists for registers 7, 8, 9, 10 and 14 and that the reset values are correct. They also show that refused writes leave storage untouched and that every nonzero opcode_2 aliases to one alternate word. The bench shows these by reading words back through the normal port after random and directed traffic.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int          DW         = 32,
  parameter logic [31:0] RST_ID     = 32'h6905_0000,
  parameter logic [31:0] RST_CTRL   = 32'h0000_0078,
  parameter logic [31:0] RST_CTYPE  = 32'h0B1A_A1AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [3:0]    req_crn,
  input  logic [3:0]    req_crm,
  input  logic [2:0]    req_op1,
  input  logic [2:0]    req_op2,
  input  logic          req_user,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic          rsp_cant,
  output logic [DW-1:0] rsp_rdata
);
  localparam int NREG = 16;

  logic [DW-1:0] bank_pri [NREG];
  logic [DW-1:0] bank_alt [NREG];
  logic          slot_ok;
  logic          accept;
  logic          alt_sel;

  assign alt_sel = (req_op2 != 3'd0);

  always_comb begin
    slot_ok = 1'b0;
    case (req_crn)
      4'd0, 4'd1:
        slot_ok = (req_crm == 4'd0);
      4'd2, 4'd3, 4'd5, 4'd6, 4'd13:
        slot_ok = (req_crm == 4'd0) && (req_op2 == 3'd0);
      4'd7:
        case (req_op2)
          3'd0:    slot_ok = (req_crm >= 4'd5) && (req_crm <= 4'd7);
          3'd1:    slot_ok = (req_crm == 4'd5) || (req_crm == 4'd6) || (req_crm == 4'd10);
          3'd4:    slot_ok = (req_crm == 4'd10);
          3'd5:    slot_ok = (req_crm == 4'd2);
          3'd6:    slot_ok = (req_crm == 4'd5);
          default: slot_ok = 1'b0;
        endcase
      4'd8:
        slot_ok = ((req_op2 == 3'd0) && (req_crm >= 4'd5) && (req_crm <= 4'd7))
               || ((req_op2 == 3'd1) && ((req_crm == 4'd5) || (req_crm == 4'd6)));
      4'd9:
        slot_ok = (req_crm <= 4'd1) && ((req_op2 == 3'd1) || (req_op2 == 3'd2));
      4'd10:
        slot_ok = (req_crm <= 4'd1) && (req_op2 == 3'd4);
      4'd14:
        slot_ok = (req_op2 == 3'd0) &&
                  ((req_crm == 4'd0) || (req_crm == 4'd3) || (req_crm == 4'd4) ||
                   (req_crm == 4'd8) || (req_crm == 4'd9));
      4'd15:
        slot_ok = (req_op2 == 3'd0) && (req_crm == 4'd1);
      default:
        slot_ok = 1'b0;
    endcase
  end

  assign accept    = req_valid && !req_user && (req_op1 == 3'd0) && slot_ok;
  assign rsp_done  = accept;
  assign rsp_cant  = req_valid && !accept;
  assign rsp_rdata = (accept && !req_write) ?
                     (alt_sel ? bank_alt[req_crn] : bank_pri[req_crn]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        bank_pri[i] <= '0;
        bank_alt[i] <= '0;
      end
      bank_pri[0] <= RST_ID[DW-1:0];
      bank_pri[1] <= RST_CTRL[DW-1:0];
      bank_alt[0] <= RST_CTYPE[DW-1:0];
    end else if (accept && req_write) begin
      if (alt_sel) bank_alt[req_crn] <= req_wdata;
      else         bank_pri[req_crn] <= req_wdata;
    end
  end
endmodule

module sysctl_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [3:0]  req_crn,
  input logic [3:0]  req_crm,
  input logic [2:0]  req_op1,
  input logic [2:0]  req_op2,
  input logic        req_user,
  input logic [31:0] req_wdata,
  input logic        rsp_done,
  input logic        rsp_cant,
  input logic [31:0] rsp_rdata
);
  AST_USER_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user) |-> rsp_cant); // R1
  AST_OP1_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op1 != 3'd0) |-> rsp_cant); // R2
  AST_DEAD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_crn == 4'd4 || req_crn == 4'd11 || req_crn == 4'd12)) |-> rsp_cant); // R4
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({rsp_done, rsp_cant})); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_done && !rsp_cant)); // R11
  AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_cant || req_write || !req_valid) |-> rsp_rdata == 32'd0); // R12
  AST_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid && req_write && rsp_done) &&
     req_valid && !req_write && rsp_done && req_crn == $past(req_crn) &&
     ((req_op2 != 3'd0) == ($past(req_op2) != 3'd0)))
    |-> rsp_rdata == $past(req_wdata)); // R13
endmodule

bind sysctl_regbank sysctl_regbank_chk u_chk (.*);

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [3:0]  req_crn = '0, req_crm = '0;
  logic [2:0]  req_op1 = '0, req_op2 = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done, rsp_cant;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_pri [16];
  logic [31:0] m_alt [16];

  always #(PERIOD/2) clk = ~clk;

  sysctl_regbank u_dut (.*);

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic bit exp_legal(bit user, logic [3:0] n, logic [3:0] m,
                                   logic [2:0] o1, logic [2:0] o2);
    logic [6:0] pr;
    if (user || o1 != 0) return 0;                              // R1 R2
    pr = {o2, m};
    if (n inside {4'd0, 4'd1}) return m == 0;                   // R3
    if (n inside {4'd2, 4'd3, 4'd5, 4'd6, 4'd13}) return pr == 0;
    if (n == 7) return pr inside {{3'd0,4'd5},{3'd0,4'd6},{3'd0,4'd7},{3'd1,4'd5},
                                  {3'd1,4'd6},{3'd1,4'd10},{3'd4,4'd10},{3'd5,4'd2},
                                  {3'd6,4'd5}};                 // R5
    if (n == 8) return pr inside {{3'd0,4'd5},{3'd0,4'd6},{3'd0,4'd7},
                                  {3'd1,4'd5},{3'd1,4'd6}};     // R6
    if (n == 9)  return (m inside {4'd0,4'd1}) && (o2 inside {3'd1,3'd2}); // R7
    if (n == 10) return (m inside {4'd0,4'd1}) && o2 == 3'd4;
    if (n == 14) return o2 == 0 && (m inside {4'd0,4'd3,4'd4,4'd8,4'd9}); // R8
    if (n == 15) return pr == {3'd0,4'd1};
    return 0;                                                   // R4
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic access(string tag, bit wr, bit user, logic [3:0] n, logic [3:0] m,
                        logic [2:0] o1, logic [2:0] o2, logic [31:0] wd);
    bit ok;
    logic [31:0] ex;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_user = user; req_crn = n; req_crm = m;
    req_op1 = o1; req_op2 = o2; req_wdata = wd;
    #1;
    ok = exp_legal(user, n, m, o1, o2);
    ex = (ok && !wr) ? ((o2 != 0) ? m_alt[n] : m_pri[n]) : 32'd0;  // R9 R12
    check({tag, " R11 status"}, {30'd0, rsp_done, rsp_cant}, {30'd0, ok, !ok});
    check({tag, " R12 data"}, rsp_rdata, ex);
    if (ok && wr) begin                                            // R13
      if (o2 != 0) m_alt[n] = wd; else m_pri[n] = wd;
    end
  endtask

  initial begin
    logic [3:0]  n, m;
    logic [2:0]  o1, o2;
    bit          u, w;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin m_pri[i] = 0; m_alt[i] = 0; end
    m_pri[0] = 32'h6905_0000; m_pri[1] = 32'h0000_0078; m_alt[0] = 32'h0B1A_A1AA;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R11 idle status", {30'd0, rsp_done, rsp_cant}, 32'd0);
    check("R12 idle data", rsp_rdata, 32'd0);
    // R10 reset values
    access("R10 id", 0, 0, 0, 0, 0, 0, 0);
    access("R10 ctrl", 0, 0, 1, 0, 0, 0, 0);
    access("R10 ctype", 0, 0, 0, 0, 0, 3, 0);
    access("R10 zero", 0, 0, 2, 0, 0, 0, 0);
    // R1 user write refused, then privileged read shows no change (R12)
    access("R1 user wr", 1, 1, 3, 0, 0, 0, 32'hDEAD_BEEF);
    access("R1 readback", 0, 0, 3, 0, 0, 0, 0);
    // R2 nonzero op1 write refused
    access("R2 op1 wr", 1, 0, 2, 0, 5, 0, 32'h1111_2222);
    access("R2 readback", 0, 0, 2, 0, 0, 0, 0);
    // R3 illegal crm write refused
    access("R3 bad crm", 1, 0, 2, 1, 0, 0, 32'h3333_4444);
    access("R3 readback", 0, 0, 2, 0, 0, 0, 0);
    // R4 dead registers
    access("R4 reg4", 1, 0, 4, 0, 0, 0, 32'h5);
    access("R4 reg11", 0, 0, 11, 0, 0, 0, 0);
    access("R4 reg12", 0, 0, 12, 0, 0, 0, 0);
    // R9 alias: op2=1 write, op2=7 read back same alternate word
    access("R9 alt wr", 1, 0, 1, 0, 0, 1, 32'hA5A5_0001);
    access("R9 alt rd", 0, 0, 1, 0, 0, 7, 0);
    access("R9 pri rd", 0, 0, 1, 0, 0, 0, 0);
    // R5 R6 R7 R8 corners
    access("R5 r7 5,2", 1, 0, 7, 2, 0, 5, 32'h7777_0052);
    access("R5 r7 5,3", 0, 0, 7, 3, 0, 5, 0);
    access("R6 r8 1,7", 0, 0, 8, 7, 0, 1, 0);
    access("R6 r8 1,6", 0, 0, 8, 6, 0, 1, 0);
    access("R7 r10 4,1", 1, 0, 10, 1, 0, 4, 32'h0A0A_0A0A);
    access("R7 r10 4,1 rd", 0, 0, 10, 1, 0, 4, 0);
    access("R7 r9 3,0", 0, 0, 9, 0, 0, 3, 0);
    access("R8 r14 0,9", 1, 0, 14, 9, 0, 0, 32'h1414_0009);
    access("R8 r15 0,1", 1, 0, 15, 1, 0, 0, 32'h1515_0001);
    access("R8 r15 0,0", 0, 0, 15, 0, 0, 0, 0);
    // R13 back-to-back write then read
    access("R13 wr", 1, 0, 13, 0, 0, 0, 32'hCAFE_F00D);
    access("R13 rd", 0, 0, 13, 0, 0, 0, 0);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      n  = 4'($urandom_range(0, 15));
      m  = ($urandom_range(0, 1) == 0) ? 4'($urandom_range(0, 2)) : 4'($urandom_range(0, 15));
      o2 = ($urandom_range(0, 2) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
      o1 = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      u  = ($urandom_range(0, 7) == 0);
      w  = ($urandom_range(0, 1) == 1);
      access("rand R3-table", w, u, n, m, o1, o2, $urandom);
    end
    @(negedge clk); req_valid = 0;
    #1;
    check("R11 final idle", {30'd0, rsp_done, rsp_cant}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule